// File: doc/BRIEF.md
# Low-Power Mode Sequencer

This block moves a small microcontroller between full operation and three reduced-power conditions. In the first, only the analog section is switched off. In the second, only the processor clock is stopped. In the third, the oscillator itself is stopped. Software selects a condition through a single five-bit control write. The block then drives the processor clock enable, the peripheral clock enable (interrupt logic, timers, serial port), the analog-section enable and the oscillator-run control.

Two events end the reduced-power conditions. An enabled pending interrupt ends the clock-stopped-CPU state. A level-sensitive external interrupt ends the oscillator-stopped state, and so does a qualified external reset. After the oscillator restarts, an internal delay counter keeps every internal clock enable low for a fixed number of oscillator cycles while the oscillator settles. The reset pin is qualified by counting consecutive high samples on the always-running oscillator clock input, so the qualification still works while the oscillator-run output is low. Two general-purpose flag bits travel in the same write and can be read back afterwards.

Top module: `pm_lowpower_ctrl`

## Requirements
- R1: After power-on reset is released, `cpu_clk_en`, `per_clk_en`, `ana_en` and `osc_run` are all 1 and `ctrl_rd` reads 0.
- R2: The control word has this layout: bit 0 is the CPU-halt request, bit 1 the oscillator-stop request, bit 2 the analog-off request and bits 4:3 the two flags. `ctrl_rd` uses the same layout. A write takes effect on the next cycle. A write is accepted only while the CPU clock is enabled and no qualified reset is active; any other write leaves `ctrl_rd` unchanged.
- R3: An accepted write with bit 0 set (and no accepted stop request) makes `cpu_clk_en` 0 from the next cycle. `per_clk_en` and `osc_run` stay 1.
- R4: While the CPU is halted, `irq_pend` sampled high at an edge clears bit 0 and brings `cpu_clk_en` back in the next cycle. The flags are kept.
- R5: Bit 2 set drops `ana_en` from the next cycle while the CPU and peripheral clocks stay on. Writing it back to 0 restores `ana_en`.
- R6: With `wdog_en` low, an accepted write with bit 1 set drives `osc_run`, `per_clk_en`, `cpu_clk_en` and `ana_en` to 0 in the next cycle, and bit 1 reads 1.
- R7: With `wdog_en` high, bit 1 of a write is dropped: it reads 0 and the clocks stay on, while the other fields of the same write still take effect.
- R8: When bits 0 and 1 are both set and the stop request is accepted, the oscillator stop wins and bit 0 reads 0.
- R9: In the stopped state, `irq_pend` alone has no effect. `lvl_wake` sampled high restarts `osc_run` in the next cycle and clears bit 1. `cpu_clk_en` and `per_clk_en` stay 0 for exactly STAB_CYC (2048) cycles counted from that edge.
- R10: A qualified reset needs `rst_pin` sampled high at 24 consecutive edges (12 cycles per machine cycle, two machine cycles). A shorter pulse has no effect.
- R11: A qualified reset ends the CPU-halted state, clears every field of the control word and restores `cpu_clk_en`.
- R12: A qualified reset ends the stopped state: `osc_run` returns, bit 1 clears, and the full STAB_CYC delay runs before the clock enables return.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_osc | input | 1 | Always-running oscillator clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| rst_pin | input | 1 | External reset pin, active high, qualified internally |
| wr_en | input | 1 | Control word write strobe |
| wr_data | input | 5 | Control word to write |
| wdog_en | input | 1 | Watchdog enabled; blocks the oscillator-stop request |
| irq_pend | input | 1 | Any enabled interrupt pending |
| lvl_wake | input | 1 | Enabled level-sensitive external interrupt |
| cpu_clk_en | output | 1 | Processor clock enable |
| per_clk_en | output | 1 | Interrupt/timer/serial clock enable |
| ana_en | output | 1 | Analog section enable |
| osc_run | output | 1 | Oscillator run control |
| ctrl_rd | output | 5 | Control word read-back |

## Verification
Two pairs of functions can fall in the same cycle. The first pair is a halt request and an oscillator-stop request arriving in one write. The bench sweeps all 32 control words with the watchdog enable both low and high, so both requests hit the same edge with and without the stop being refused. The bench computes the winning state and the read-back word arithmetically. The second pair is reset qualification and wake-up. The bench holds the reset pin for 23 and then 24 edges while the CPU is halted and while the oscillator is stopped. It then checks that only the qualified pulse ends the state and that the settling delay is counted in full.

// File: rtl/pm_pkg.sv
package pm_pkg;
  typedef enum logic [1:0] {
    PM_RUN  = 2'd0,
    PM_IDLE = 2'd1,
    PM_DOWN = 2'd2,
    PM_STAB = 2'd3
  } pm_state_e;

  typedef struct packed {
    logic [1:0] gf;
    logic       stby;
    logic       pd;
    logic       idle;
  } pm_ctrl_t;

  localparam int CTRL_W = $bits(pm_ctrl_t);
endpackage

// File: rtl/pm_rst_qual.sv
module pm_rst_qual #(
  parameter int QUAL_CYC = 24
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rst_pin,
  output logic rst_qual
);
  localparam int CW = $clog2(QUAL_CYC + 1);
  localparam logic [CW-1:0] CNT_MAX = CW'(QUAL_CYC);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    if (!rst_pin)             cnt_d = '0;
    else if (cnt_q == CNT_MAX) cnt_d = cnt_q;
    else                      cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign rst_qual = (cnt_q == CNT_MAX);

  // R10
  pin_low_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rst_pin |=> !rst_qual);
  // R10
  qual_needs_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_qual |-> $past(rst_pin));
endmodule

// File: rtl/pm_stab_cnt.sv
module pm_stab_cnt #(
  parameter int STAB_CYC = 2048
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic done
);
  localparam int CW = $clog2(STAB_CYC);
  localparam logic [CW-1:0] LOAD = CW'(STAB_CYC - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          busy_q, busy_d;

  always_comb begin
    cnt_d  = cnt_q;
    busy_d = busy_q;
    if (start) begin
      cnt_d  = LOAD;
      busy_d = 1'b1;
    end else if (busy_q) begin
      if (cnt_q == '0) busy_d = 1'b0;
      else             cnt_d  = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      busy_q <= busy_d;
    end
  end

  assign busy = busy_q;
  assign done = busy_q && (cnt_q == '0);

  // independent up-counter used only by the window check
  logic [CW-1:0] win_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      win_q <= '0;
    else if (start)  win_q <= '0;
    else if (busy_q) win_q <= win_q + 1'b1;
  end

  // R9
  full_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (win_q == LOAD));
  // R12
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy);
endmodule

// File: rtl/pm_ctrl_regs.sv
module pm_ctrl_regs
  import pm_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     clr,
  input  logic     wr_acc,
  input  pm_ctrl_t wr_word,
  input  logic     pd_allow,
  input  logic     hw_idle_clr,
  input  logic     hw_pd_clr,
  output pm_ctrl_t ctrl_q,
  output logic     idle_go,
  output logic     pd_go
);
  pm_ctrl_t ctrl_d;

  assign pd_go   = wr_acc && wr_word.pd && pd_allow;
  assign idle_go = wr_acc && wr_word.idle && !pd_go;

  always_comb begin
    ctrl_d = ctrl_q;
    if (clr) begin
      ctrl_d = '0;
    end else begin
      if (wr_acc) begin
        ctrl_d.gf   = wr_word.gf;
        ctrl_d.stby = wr_word.stby;
        ctrl_d.pd   = pd_go;
        ctrl_d.idle = idle_go;
      end
      if (hw_idle_clr) ctrl_d.idle = 1'b0;
      if (hw_pd_clr)   ctrl_d.pd   = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= '0;
    else        ctrl_q <= ctrl_d;
  end

  // R2
  flags_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(wr_acc) && !$past(clr)) |-> $stable(ctrl_q.gf));
  // R8
  stop_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_go && !clr) |=> (ctrl_q.pd && !ctrl_q.idle));
endmodule

// File: rtl/pm_seq.sv
module pm_seq
  import pm_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      rst_qual,
  input  logic      idle_go,
  input  logic      pd_go,
  input  logic      irq_pend,
  input  logic      lvl_wake,
  input  logic      stab_done,
  output pm_state_e state,
  output logic      stab_start,
  output logic      idle_clr,
  output logic      pd_clr,
  output logic      cpu_clk_en,
  output logic      per_clk_en,
  output logic      osc_run
);
  pm_state_e state_q, state_d;

  always_comb begin
    state_d    = state_q;
    stab_start = 1'b0;
    idle_clr   = 1'b0;
    pd_clr     = 1'b0;
    unique case (state_q)
      PM_RUN: begin
        if (!rst_qual) begin
          if (pd_go)        state_d = PM_DOWN;
          else if (idle_go) state_d = PM_IDLE;
        end
      end
      PM_IDLE: begin
        if (rst_qual || irq_pend) begin
          state_d  = PM_RUN;
          idle_clr = 1'b1;
        end
      end
      PM_DOWN: begin
        if (rst_qual || lvl_wake) begin
          state_d    = PM_STAB;
          stab_start = 1'b1;
          pd_clr     = 1'b1;
        end
      end
      PM_STAB: begin
        if (stab_done) state_d = PM_RUN;
      end
      default: state_d = PM_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= PM_RUN;
    else        state_q <= state_d;
  end

  assign state      = state_q;
  assign cpu_clk_en = (state_q == PM_RUN);
  assign per_clk_en = (state_q == PM_RUN) || (state_q == PM_IDLE);
  assign osc_run    = (state_q != PM_DOWN);

  // R4
  irq_ends_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PM_IDLE && irq_pend) |=> cpu_clk_en);
  // R9
  stays_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PM_DOWN && !lvl_wake && !rst_qual) |=> !osc_run);
endmodule

// File: rtl/pm_lowpower_ctrl.sv
module pm_lowpower_ctrl
  import pm_pkg::*;
#(
  parameter int MC_OSC      = 12,
  parameter int RST_MC      = 2,
  parameter int STAB_CYC    = 2048,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_osc,
  input  logic              rst_n,
  input  logic              rst_pin,
  input  logic              wr_en,
  input  logic [CTRL_W-1:0] wr_data,
  input  logic              wdog_en,
  input  logic              irq_pend,
  input  logic              lvl_wake,
  output logic              cpu_clk_en,
  output logic              per_clk_en,
  output logic              ana_en,
  output logic              osc_run,
  output logic [CTRL_W-1:0] ctrl_rd
);
  localparam int QUAL_CYC = MC_OSC * RST_MC;

  // asynchronous assert, synchronous release
  logic [SYNC_STAGES-1:0] sync_q;
  always_ff @(posedge clk_osc or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], 1'b1};
  end
  logic core_rst_n;
  assign core_rst_n = sync_q[SYNC_STAGES-1];

  logic      rst_qual;
  logic      wr_acc, idle_go, pd_go;
  logic      stab_start, stab_busy, stab_done;
  logic      idle_clr, pd_clr;
  pm_state_e state;
  pm_ctrl_t  ctrl_q;

  pm_rst_qual #(.QUAL_CYC(QUAL_CYC)) u_qual (
    .clk      (clk_osc),
    .rst_n    (core_rst_n),
    .rst_pin  (rst_pin),
    .rst_qual (rst_qual)
  );

  assign wr_acc = wr_en && cpu_clk_en && !rst_qual;

  pm_ctrl_regs u_regs (
    .clk         (clk_osc),
    .rst_n       (core_rst_n),
    .clr         (rst_qual),
    .wr_acc      (wr_acc),
    .wr_word     (pm_ctrl_t'(wr_data)),
    .pd_allow    (!wdog_en),
    .hw_idle_clr (idle_clr),
    .hw_pd_clr   (pd_clr),
    .ctrl_q      (ctrl_q),
    .idle_go     (idle_go),
    .pd_go       (pd_go)
  );

  pm_stab_cnt #(.STAB_CYC(STAB_CYC)) u_stab (
    .clk   (clk_osc),
    .rst_n (core_rst_n),
    .start (stab_start),
    .busy  (stab_busy),
    .done  (stab_done)
  );

  pm_seq u_seq (
    .clk        (clk_osc),
    .rst_n      (core_rst_n),
    .rst_qual   (rst_qual),
    .idle_go    (idle_go),
    .pd_go      (pd_go),
    .irq_pend   (irq_pend),
    .lvl_wake   (lvl_wake),
    .stab_done  (stab_done),
    .state      (state),
    .stab_start (stab_start),
    .idle_clr   (idle_clr),
    .pd_clr     (pd_clr),
    .cpu_clk_en (cpu_clk_en),
    .per_clk_en (per_clk_en),
    .osc_run    (osc_run)
  );

  assign ana_en  = per_clk_en && !ctrl_q.stby;
  assign ctrl_rd = ctrl_q;

  // R7
  refused_stop_chk: assert property (@(posedge clk_osc) disable iff (!core_rst_n)
    (wr_acc && wr_data[1] && wdog_en) |=> (osc_run && !ctrl_rd[1]));
  // R9
  settle_first_chk: assert property (@(posedge clk_osc) disable iff (!core_rst_n)
    $rose(osc_run) |-> (!cpu_clk_en && stab_busy));
  // R3
  halt_matches_bit_chk: assert property (@(posedge clk_osc) disable iff (!core_rst_n)
    (per_clk_en && !cpu_clk_en) |-> (ctrl_rd[0] && state == PM_IDLE));
  // R6
  down_quiet_chk: assert property (@(posedge clk_osc) disable iff (!core_rst_n)
    !osc_run |-> (!per_clk_en && !ana_en && ctrl_rd[1]));
endmodule

// File: tb/test_pm_lowpower_ctrl.sv
module test_pm_lowpower_ctrl;
  localparam int STAB = 2048;

  logic       clk = 1'b0;
  logic       rst_n, rst_pin, wr_en, wdog_en, irq_pend, lvl_wake;
  logic [4:0] wr_data;
  logic       cpu_clk_en, per_clk_en, ana_en, osc_run;
  logic [4:0] ctrl_rd;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  pm_lowpower_ctrl i_pm_lowpower_ctrl (
    .clk_osc    (clk),
    .rst_n      (rst_n),
    .rst_pin    (rst_pin),
    .wr_en      (wr_en),
    .wr_data    (wr_data),
    .wdog_en    (wdog_en),
    .irq_pend   (irq_pend),
    .lvl_wake   (lvl_wake),
    .cpu_clk_en (cpu_clk_en),
    .per_clk_en (per_clk_en),
    .ana_en     (ana_en),
    .osc_run    (osc_run),
    .ctrl_rd    (ctrl_rd)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [3:0] outs();
    return {osc_run, per_clk_en, cpu_clk_en, ana_en};
  endfunction

  task automatic do_write(input logic [4:0] v);
    @(negedge clk); wr_en = 1'b1; wr_data = v;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic pulse_irq();
    @(negedge clk); irq_pend = 1'b1;
    @(negedge clk); irq_pend = 1'b0;
  endtask

  task automatic pulse_wake();
    @(negedge clk); lvl_wake = 1'b1;
    @(negedge clk); lvl_wake = 1'b0;
  endtask

  // pin high for n sampling edges, then one more edge for the effect
  task automatic rst_pulse(input int n);
    @(negedge clk); rst_pin = 1'b1;
    repeat (n) @(negedge clk);
    rst_pin = 1'b0;
    @(negedge clk);
  endtask

  task automatic settle_len(output int n);
    n = 0;
    while (!cpu_clk_en && n < 5000) begin
      n++;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int n;
    rst_n = 1'b0; rst_pin = 1'b0; wr_en = 1'b0; wr_data = '0;
    wdog_en = 1'b0; irq_pend = 1'b0; lvl_wake = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 outs", outs(), 4'b1111);
    chk("R1 ctrl", ctrl_rd, 5'd0);

    // sweep every control word with the watchdog enable low and high
    for (int wd = 0; wd < 2; wd++) begin
      for (int d = 0; d < 32; d++) begin
        logic [4:0] v;
        logic pd_acc, idl;
        string tag;
        v = d[4:0];
        wdog_en = wd[0];
        pd_acc = v[1] && (wd == 0);
        idl = v[0] && !pd_acc;
        if (pd_acc)                 tag = v[0] ? "R8" : "R6";
        else if (idl)               tag = "R3";
        else if (v[1])              tag = "R7";
        else if (v[2])              tag = "R5";
        else                        tag = "R2";
        do_write(v);
        chk({tag, " ctrl"}, ctrl_rd, {v[4:3], v[2], pd_acc, idl});
        chk({tag, " outs"}, outs(),
            {!pd_acc, !pd_acc, !(pd_acc || idl), !pd_acc && !v[2]});
        if (idl) begin
          // R2 write while halted is ignored
          do_write(~v);
          chk("R2 halted write", ctrl_rd, {v[4:3], v[2], 2'b01});
          pulse_irq();
          chk("R4 cpu back", outs(), {3'b111, !v[2]});
          chk("R4 flags kept", ctrl_rd, {v[4:3], v[2], 2'b00});
        end
        if (pd_acc) begin
          pulse_irq();
          chk("R9 irq ignored", outs(), 4'b0000);
          pulse_wake();
          chk("R9 osc restart", outs(), 4'b1000);
          chk("R9 pd cleared", ctrl_rd, {v[4:3], v[2], 2'b00});
          settle_len(n);
          chk("R9 settle length", n, STAB);
        end
        do_write(5'd0);
        chk("R5 restored", outs(), 4'b1111);
      end
    end
    wdog_en = 1'b0;

    // R10 short pulse while halted: no effect
    do_write(5'b11001);
    rst_pulse(23);
    chk("R10 short pulse", ctrl_rd, 5'b11001);
    chk("R10 still halted", outs(), 4'b1101);
    // R11 qualified pulse ends halt and clears the word
    rst_pulse(24);
    chk("R11 cleared", ctrl_rd, 5'd0);
    chk("R11 cpu back", outs(), 4'b1111);

    // R10 short pulse while stopped: no effect
    do_write(5'b10110);
    chk("R6 stopped", outs(), 4'b0000);
    rst_pulse(23);
    chk("R10 short in stop", outs(), 4'b0000);
    // R12 qualified pulse restarts oscillator
    rst_pulse(24);
    chk("R12 osc restart", outs(), 4'b1000);
    chk("R12 pd cleared", ctrl_rd[1], 1'b0);
    settle_len(n);
    chk("R12 settle length", n, STAB);
    chk("R12 cleared word", ctrl_rd, 5'd0);
    chk("R12 outs", outs(), 4'b1111);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule